// File: doc/BRIEF.md
# Pre-Trigger Circular Capture Controller

This block sequences one acquisition for a sampling oscilloscope. The capture memory sits outside the block. Samples arrive on a valid/ready stream, and the source raises `s_valid` once per sample-rate tick, so the sample rate is set by how often the tick fires. Every accepted sample goes out on a write port to the memory. The write address walks the buffer in circular order and wraps from the last slot back to zero. The block has no back-pressure of its own toward the memory: a write happens in the same cycle as the handshake.

After a start command the controller first fills half of the buffer. Until that point it ignores the threshold trigger, so that the pre-trigger region never holds stale data. It then arms and waits for the sample stream to cross a programmed level in the selected direction. When the crossing arrives it latches the buffer address of the crossing sample and accepts no further trigger. A separate post-trigger counter lets a programmed number of samples through after the trigger and then stops acceptance and reports completion. Half-buffer and end-of-buffer pulses continue while the buffer wraps, so a consumer can work on one half while the other half fills. An abort returns the controller to idle from any state.

Stream rules: `s_ready` is high only while a capture is in progress and does not depend on `s_valid`. A sample is taken in any cycle in which both signals are high. Outside a capture, offered samples are left untaken, and the source may hold them or drop them.

Top module: `scope_capture_ctrl`

## Requirements
- R1: An accepted sample (`s_valid && s_ready`) raises `wr_en` in the same cycle, with `wr_data = s_data` and `wr_addr` equal to the slot count since start modulo DEPTH (0, 1, …, DEPTH-1, 0, …).
- R2: `s_ready` is high exactly while the controller is filling, armed or counting post-trigger samples. In all other states no sample is taken and no write happens.
- R3: `start` in idle or done clears the address to 0, clears `trig_valid`, latches `post_len` and begins filling, and `busy` goes high in the next cycle. `start` during a capture has no effect. After reset the controller is idle with all flags low.
- R4: The trigger is ignored until DEPTH/2 samples of the capture have been accepted. `armed` rises in the cycle after the DEPTH/2-th sample.
- R5: A crossing is judged on unsigned values against the previous accepted sample of the same capture. With `edge_fall=0` it is `prev < thr && cur >= thr`, and with `edge_fall=1` it is `prev >= thr && cur < thr`. The first sample of a capture is never a crossing, and crossings while filling are discarded although they still update the history.
- R6: A crossing while armed sets `trig_valid` in the next cycle, sets `trig_idx` to the address the crossing sample was written to, and drops `armed`. Only one trigger is accepted per capture.
- R7: After the trigger sample exactly `post_len` further samples are accepted, and then `done` rises in the cycle after the last one. With `post_len = 0` the trigger sample is the last. `post_len` is ADDR_W bits wide, so it cannot exceed DEPTH-1.
- R8: While done, `trig_idx` and `trig_valid` hold and no sample is accepted until the next `start` or `abort`.
- R9: `abort` forces idle in the next cycle from any state, clears `trig_valid`, and takes priority over `start`.
- R10: `half_evt` pulses for one cycle after a write to address DEPTH/2-1, and `full_evt` pulses after a write to DEPTH-1. Both pulse in every capture state, including after wraps.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a capture (idle or done only) |
| abort | input | 1 | Return to idle from any state |
| post_len | input | ADDR_W | Samples to take after the trigger sample |
| thr | input | DATA_W | Trigger threshold, unsigned |
| edge_fall | input | 1 | 0 = rising crossing, 1 = falling crossing |
| s_valid | input | 1 | Sample offered (one per rate tick) |
| s_ready | output | 1 | Controller takes samples |
| s_data | input | DATA_W | Sample value |
| wr_en | output | 1 | Buffer write strobe |
| wr_addr | output | ADDR_W | Buffer write address |
| wr_data | output | DATA_W | Buffer write data |
| trig_valid | output | 1 | Trigger index captured this run |
| trig_idx | output | ADDR_W | Buffer address of trigger sample |
| armed | output | 1 | Waiting for a crossing |
| busy | output | 1 | Capture in progress |
| done | output | 1 | Capture finished |
| half_evt | output | 1 | Pulse: first half of buffer just written |
| full_evt | output | 1 | Pulse: second half of buffer just written |

## Verification
Most internal faults become visible at the ports within one sample of the point where they go wrong. A write pointer that slips shows up on `wr_addr` at the next accepted sample. A wrong crossing history moves the trigger, so `trig_idx` and the rise of `trig_valid` differ one cycle after the crossing sample. An off-by-one in the post-trigger counter or in the half-fill point shifts `done` or `armed` by exactly one accepted sample. The bench therefore steps a reference model one cycle at a time and compares every output in every cycle, so the first diverging cycle is the one that is reported.

// File: rtl/scap_pkg.sv
package scap_pkg;
  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_FILL  = 3'd1,
    ST_ARMED = 3'd2,
    ST_POST  = 3'd3,
    ST_DONE  = 3'd4
  } cap_state_e;
endpackage

// File: rtl/scap_ring_ptr.sv
module scap_ring_ptr #(
  parameter int ADDR_W = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              adv,
  output logic [ADDR_W-1:0] ptr,
  output logic              half_evt,
  output logic              full_evt
);
  localparam int DEPTH = 1 << ADDR_W;
  localparam logic [ADDR_W-1:0] HALF_LAST = ADDR_W'(DEPTH / 2 - 1);
  localparam logic [ADDR_W-1:0] LAST      = ADDR_W'(DEPTH - 1);

  logic [ADDR_W-1:0] ptr_q;
  logic              half_q, full_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr_q  <= '0;
      half_q <= 1'b0;
      full_q <= 1'b0;
    end else begin
      half_q <= adv && (ptr_q == HALF_LAST);
      full_q <= adv && (ptr_q == LAST);
      if (clr)      ptr_q <= '0;
      else if (adv) ptr_q <= ptr_q + 1'b1;
    end
  end

  assign ptr      = ptr_q;
  assign half_evt = half_q;
  assign full_evt = full_q;

  p_step_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (adv && !clr) |=> ptr_q == ADDR_W'($past(ptr_q) + 1'b1));
  p_wrap_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (adv && !clr && ptr_q == LAST) |=> ptr_q == '0);
  p_half_src_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (adv && ptr_q == HALF_LAST) |=> half_evt);
endmodule

// File: rtl/scap_xing.sv
module scap_xing #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              adv,
  input  logic [DATA_W-1:0] sample,
  input  logic [DATA_W-1:0] thr,
  input  logic              falling,
  output logic              hit
);
  logic [DATA_W-1:0] prev_q;
  logic              prev_ok_q;
  logic              prev_hi, cur_hi;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q    <= '0;
      prev_ok_q <= 1'b0;
    end else if (clr) begin
      prev_ok_q <= 1'b0;
    end else if (adv) begin
      prev_q    <= sample;
      prev_ok_q <= 1'b1;
    end
  end

  always_comb begin
    prev_hi = prev_q >= thr;
    cur_hi  = sample >= thr;
    if (falling) hit = prev_ok_q && prev_hi && !cur_hi;
    else         hit = prev_ok_q && !prev_hi && cur_hi;
  end

  p_prev_track_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (adv && !clr) |=> (prev_ok_q && prev_q == $past(sample)));
  p_clr_forget_r5: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> !prev_ok_q);
endmodule

// File: rtl/scap_post_cnt.sv
module scap_post_cnt #(
  parameter int ADDR_W = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic              adv,
  input  logic [ADDR_W-1:0] len,
  output logic [ADDR_W-1:0] cnt,
  output logic              last
);
  logic [ADDR_W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    cnt_q <= '0;
    else if (load) cnt_q <= '0;
    else if (adv)  cnt_q <= cnt_q + 1'b1;
  end

  assign cnt  = cnt_q;
  assign last = (ADDR_W'(cnt_q + 1'b1) == len);

  p_load_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> cnt_q == '0);
endmodule

// File: rtl/scope_capture_ctrl.sv
module scope_capture_ctrl
  import scap_pkg::*;
#(
  parameter int ADDR_W = 5,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              abort,
  input  logic [ADDR_W-1:0] post_len,
  input  logic [DATA_W-1:0] thr,
  input  logic              edge_fall,
  input  logic              s_valid,
  output logic              s_ready,
  input  logic [DATA_W-1:0] s_data,
  output logic              wr_en,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [DATA_W-1:0] wr_data,
  output logic              trig_valid,
  output logic [ADDR_W-1:0] trig_idx,
  output logic              armed,
  output logic              busy,
  output logic              done,
  output logic              half_evt,
  output logic              full_evt
);
  localparam int DEPTH = 1 << ADDR_W;
  localparam logic [ADDR_W-1:0] HALF_LAST = ADDR_W'(DEPTH / 2 - 1);

  cap_state_e        st_q, st_d;
  logic              capturing, acc, launch, trig_fire;
  logic              xing_hit, post_last;
  logic [ADDR_W-1:0] len_q, post_cnt, ptr;
  logic              tv_q;
  logic [ADDR_W-1:0] tidx_q;

  assign capturing = (st_q == ST_FILL) || (st_q == ST_ARMED) || (st_q == ST_POST);
  assign acc       = s_valid && capturing;
  assign launch    = !abort && start && ((st_q == ST_IDLE) || (st_q == ST_DONE));
  assign trig_fire = !abort && acc && (st_q == ST_ARMED) && xing_hit;

  scap_ring_ptr #(.ADDR_W(ADDR_W)) u_ptr (
    .clk(clk), .rst_n(rst_n), .clr(launch), .adv(acc),
    .ptr(ptr), .half_evt(half_evt), .full_evt(full_evt)
  );

  scap_xing #(.DATA_W(DATA_W)) u_xing (
    .clk(clk), .rst_n(rst_n), .clr(launch), .adv(acc),
    .sample(s_data), .thr(thr), .falling(edge_fall), .hit(xing_hit)
  );

  scap_post_cnt #(.ADDR_W(ADDR_W)) u_post (
    .clk(clk), .rst_n(rst_n), .load(trig_fire),
    .adv(acc && (st_q == ST_POST)), .len(len_q),
    .cnt(post_cnt), .last(post_last)
  );

  always_comb begin
    st_d = st_q;
    if (abort) begin
      st_d = ST_IDLE;
    end else begin
      unique case (st_q)
        ST_IDLE, ST_DONE: if (start) st_d = ST_FILL;
        ST_FILL:  if (acc && ptr == HALF_LAST) st_d = ST_ARMED;
        ST_ARMED: if (trig_fire) st_d = (len_q == '0) ? ST_DONE : ST_POST;
        ST_POST:  if (acc && post_last) st_d = ST_DONE;
        default:  st_d = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      len_q  <= '0;
      tv_q   <= 1'b0;
      tidx_q <= '0;
    end else begin
      st_q <= st_d;
      if (launch) len_q <= post_len;
      if (abort || launch) begin
        tv_q <= 1'b0;
      end else if (trig_fire) begin
        tv_q   <= 1'b1;
        tidx_q <= ptr;
      end
    end
  end

  assign s_ready    = capturing;
  assign wr_en      = acc;
  assign wr_addr    = ptr;
  assign wr_data    = s_data;
  assign trig_valid = tv_q;
  assign trig_idx   = tidx_q;
  assign armed      = (st_q == ST_ARMED);
  assign busy       = capturing;
  assign done       = (st_q == ST_DONE);

  p_fill_no_trig_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_FILL) |-> !trig_valid);
  p_arm_after_half_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_FILL && acc && ptr == HALF_LAST && !abort) |=> armed);
  p_one_trig_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (trig_valid && !launch && !abort) |=> (trig_valid && $stable(trig_idx)));
  p_cnt_bound_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_POST) |-> post_cnt < len_q);
  p_done_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_DONE && !start && !abort) |=> (done && $stable(trig_idx) && !s_ready));
  p_abort_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
    abort |=> (!busy && !done && !trig_valid));
  p_start_fill_r3: assert property (@(posedge clk) disable iff (!rst_n)
    launch |=> (busy && !armed && wr_addr == '0));
endmodule

// File: tb/sim_scope_capture_ctrl.sv
module sim_scope_capture_ctrl;
  localparam int AW = 5;
  localparam int DW = 8;
  localparam int DEPTH = 1 << AW;
  localparam int HALF = DEPTH / 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 0, abort = 0, edge_fall = 0, s_valid = 0;
  logic [AW-1:0] post_len = '0;
  logic [DW-1:0] thr = '0, s_data = '0;
  logic s_ready, wr_en, trig_valid, armed, busy, done, half_evt, full_evt;
  logic [AW-1:0] wr_addr, trig_idx;
  logic [DW-1:0] wr_data;

  int n_tests = 0;
  int n_fail = 0;

  int m_st = 0, m_ptr = 0, m_prev = 0, m_pok = 0, m_tv = 0, m_tidx = 0;
  int m_cnt = 0, m_len = 0, m_half = 0, m_full = 0;

  always #10 clk = ~clk;

  scope_capture_ctrl #(.ADDR_W(AW), .DATA_W(DW)) u0 (
    .clk(clk), .rst_n(rst_n), .start(start), .abort(abort), .post_len(post_len),
    .thr(thr), .edge_fall(edge_fall), .s_valid(s_valid), .s_ready(s_ready),
    .s_data(s_data), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .trig_valid(trig_valid), .trig_idx(trig_idx), .armed(armed), .busy(busy),
    .done(done), .half_evt(half_evt), .full_evt(full_evt)
  );

  task automatic chk(string tag, int act, int exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: got %0d expected %0d", tag, act, exp);
    end
  endtask

  function automatic int is_cross(int prev, int pok, int cur, int t, int fall);
    if (pok == 0) return 0;
    if (fall != 0) return (prev >= t && cur < t) ? 1 : 0;
    return (prev < t && cur >= t) ? 1 : 0;
  endfunction

  function automatic int ready_of(int st);
    return (st >= 1 && st <= 3) ? 1 : 0;
  endfunction

  task automatic step(int v, int d, int st, int ab);
    int acc, hit, nst;
    @(negedge clk);
    s_valid = v[0]; s_data = DW'(d); start = st[0]; abort = ab[0];
    #1;
    acc = v & ready_of(m_st);
    chk("R2 s_ready", int'(s_ready), ready_of(m_st));
    chk("R1 wr_en", int'(wr_en), acc);
    if (acc != 0) begin
      chk("R1 wr_addr", int'(wr_addr), m_ptr);
      chk("R1 wr_data", int'(wr_data), d);
    end
    @(posedge clk);
    hit = is_cross(m_prev, m_pok, d, int'(thr), int'(edge_fall));
    m_half = (acc != 0 && m_ptr == HALF - 1) ? 1 : 0;
    m_full = (acc != 0 && m_ptr == DEPTH - 1) ? 1 : 0;
    nst = m_st;
    if (ab != 0) begin
      nst = 0; m_tv = 0;
    end else if (st != 0 && (m_st == 0 || m_st == 4)) begin
      nst = 1; m_tv = 0; m_len = int'(post_len);
    end else if (acc != 0) begin
      if (m_st == 1 && m_ptr == HALF - 1) nst = 2;
      else if (m_st == 2 && hit != 0) begin
        m_tv = 1; m_tidx = m_ptr; m_cnt = 0;
        nst = (m_len == 0) ? 4 : 3;
      end else if (m_st == 3) begin
        if (m_cnt + 1 == m_len) nst = 4;
        else m_cnt++;
      end
    end
    if (ab == 0 && st != 0 && (m_st == 0 || m_st == 4)) begin
      m_ptr = 0; m_pok = 0;
    end else if (acc != 0) begin
      m_ptr = (m_ptr + 1) % DEPTH; m_prev = d; m_pok = 1;
    end
    m_st = nst;
    #1;
    chk("R6 trig_valid", int'(trig_valid), m_tv);
    if (m_tv != 0) chk("R6 trig_idx", int'(trig_idx), m_tidx);
    chk("R4 armed", int'(armed), (m_st == 2) ? 1 : 0);
    chk("R3 busy", int'(busy), ready_of(m_st));
    chk("R7 done", int'(done), (m_st == 4) ? 1 : 0);
    chk("R10 half_evt", int'(half_evt), m_half);
    chk("R10 full_evt", int'(full_evt), m_full);
  endtask

  task automatic summary();
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_tests++; n_fail++;
    $display("FAIL watchdog: got 1 expected 0");
    summary();
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed_c0de));
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    #1;
    chk("R3 reset busy", int'(busy), 0);
    chk("R3 reset done", int'(done), 0);
    chk("R3 reset trig_valid", int'(trig_valid), 0);
    chk("R2 reset s_ready", int'(s_ready), 0);

    // Directed: a crossing while filling is discarded, post_len zero
    thr = 8'd100; edge_fall = 1'b0; post_len = '0;
    step(1, 200, 0, 0);
    chk("R2 idle no write", int'(wr_en), 0);
    step(0, 0, 1, 0);
    for (int i = 0; i < HALF; i++) step(1, (i == 1) ? 150 : 50, 0, 0);
    chk("R5 fill crossing ignored", int'(trig_valid), 0);
    chk("R4 armed at half", int'(armed), 1);
    step(1, 60, 0, 0);
    step(1, 100, 0, 0);
    chk("R7 zero length ends on trigger", int'(done), 1);
    chk("R6 trig index", int'(trig_idx), HALF + 1);
    step(1, 10, 0, 0);
    step(1, 200, 0, 0);
    chk("R8 done holds, no accept", int'(wr_en), 0);
    chk("R8 trig index held", int'(trig_idx), HALF + 1);

    // Directed: falling edge, maximum length, wraps with gaps
    thr = 8'd10; edge_fall = 1'b1; post_len = AW'(DEPTH - 1);
    step(0, 0, 1, 0);
    for (int i = 0; i < 400 && m_st != 4; i++)
      step((i % 3 != 0) ? 1 : 0, (i % 40 == 30) ? 5 : 20, 0, 0);
    chk("R7 max length completes", int'(done), 1);

    // Directed: start during capture ignored, abort beats start
    thr = 8'd128; edge_fall = 1'b0; post_len = AW'(3);
    step(0, 0, 1, 0);
    for (int i = 0; i < 5; i++) step(1, i, 0, 0);
    step(1, 7, 1, 0);
    chk("R3 start while busy ignored", int'(busy), 1);
    step(1, 9, 1, 1);
    chk("R9 abort to idle", int'(busy), 0);
    chk("R9 abort clears trigger", int'(trig_valid), 0);

    // Constrained random captures
    for (int c = 0; c < 40; c++) begin
      thr = DW'($urandom_range(20, 235));
      edge_fall = 1'($urandom_range(0, 1));
      post_len = AW'($urandom_range(0, DEPTH - 1));
      step(0, 0, 1, 0);
      for (int k = 0; k < 600 && m_st != 4 && m_st != 0; k++)
        step(($urandom_range(0, 9) < 7) ? 1 : 0, $urandom_range(0, 255),
             ($urandom_range(0, 199) == 0) ? 1 : 0,
             ($urandom_range(0, 499) == 0) ? 1 : 0);
      if (m_st != 4) step(0, 0, 0, 1);
    end

    summary();
    $finish;
  end
endmodule